// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block tracks which operating mode a small microcontroller core is in and turns that mode into clock-gate enables and power status flags. The core's configuration decides the run mode. A 3-bit divider select and a fast/slow select bit choose between full-speed running (NORMAL) and running from the low-speed internal oscillator (SLOW). A halt strobe from the core moves the controller into one of four low-power modes. The mode chosen depends on an idle-enable bit, a keep-system-clock bit, and whether the watchdog or the low-voltage detector is on.

Moving from SLOW back to NORMAL goes through a SPINUP state. The core stays on the slow clock in SPINUP until the high-speed oscillator reports that it is stable. A wake-up event ends any low-power mode and returns the controller to the mode it left when the halt came. Entering low power sets a power-down flag and clears the watchdog time-out flag. Entering the deepest mode also gives the watchdog a one-cycle clear pulse.

States and their `mode` codes: NORMAL=0, SLOW=1, SLEEP0=2, SLEEP1=3, IDLE0=4, IDLE1=5, SPINUP=6. The transitions are:
- go-slow: NORMAL to SLOW.
- spin-up: SLOW to SPINUP.
- settle: SPINUP to NORMAL.
- abort: SPINUP to SLOW.
- halt: from NORMAL, SLOW or SPINUP into SLEEP0, SLEEP1, IDLE0 or IDLE1.
- wake: from a low-power state back to the saved run state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset gives the following: `mode`=0 (NORMAL), `pd_flag`=0, `to_flag`=0, `wdt_clr`=0, all four clock enables 1 and `hs_clk_sel`=1.
- R2: In NORMAL with no halt, the mode becomes SLOW (1) at the next edge when a slow selection is made. A slow selection means `fast_sel`=0 and `clk_div_sel` is 000 or 001. `hs_clk_sel` is 0 in SLOW.
- R3: In SLOW with no halt and no slow selection, the controller goes to SPINUP (6). It stays in SPINUP while `hosc_ready`=0. At the edge where `hosc_ready`=1 it goes to NORMAL. A slow selection seen in SPINUP returns it to SLOW instead. Slow selection takes priority over `hosc_ready`.
- R4: A halt accepted with `idle_en`=0 goes to SLEEP0 (2) when `wdt_on` and `lvd_on` are both 0. It goes to SLEEP1 (3) otherwise.
- R5: A halt accepted with `idle_en`=1 goes to IDLE0 (4) when `keep_sysclk`=0 and to IDLE1 (5) when it is 1.
- R6: The clock enables follow the mode.
  - `cpu_clk_en` is 1 only in NORMAL, SLOW and SPINUP.
  - `sys_clk_en` is 1 in those three modes and in IDLE1.
  - `wdt_clk_en` is 0 only in SLEEP0.
  - `tbase_clk_en` is 0 only in SLEEP0 and SLEEP1.
  - `hs_clk_sel` is 1 in NORMAL, and in a low-power mode entered from NORMAL.
- R7: `wake_evt` in a low-power mode returns the controller at the next edge to the run mode saved at halt. NORMAL is saved when the halt came in NORMAL. SLOW is saved when it came in SLOW or SPINUP.
- R8: `halt_req` in a low-power mode has no effect on `mode` or on any flag.
- R9: `pd_flag` becomes 1 at the edge that accepts a halt. Only `pd_clr` or reset clears it. A halt accepted in the same cycle as `pd_clr` wins.
- R10: `to_flag` becomes 1 at an edge where `wdt_expire`=1. An accepted halt clears it, and the halt wins over a simultaneous expiry.
- R11: `wdt_clr` is high for exactly the first cycle of SLEEP0, and only after entry into SLEEP0.
- R12: A halt takes priority over any clock-select change seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div_sel | input | 3 | Clock divider select; 000/001 with fast_sel=0 select slow running |
| fast_sel | input | 1 | 1 forces high-speed running |
| idle_en | input | 1 | 1: halt enters an IDLE mode; 0: a SLEEP mode |
| keep_sysclk | input | 1 | In idle, 1 keeps the system clock to peripherals |
| wdt_on | input | 1 | Watchdog enabled |
| lvd_on | input | 1 | Low-voltage detector enabled |
| halt_req | input | 1 | Halt instruction strobe |
| wake_evt | input | 1 | Wake-up event |
| hosc_ready | input | 1 | High-speed oscillator stable |
| pd_clr | input | 1 | Clears the power-down flag |
| wdt_expire | input | 1 | Watchdog time-out event |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| wdt_clk_en | output | 1 | Watchdog clock gate enable |
| tbase_clk_en | output | 1 | Time-base clock gate enable |
| hs_clk_sel | output | 1 | 1 when the high-speed clock is selected |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Watchdog time-out status flag |

## Verification
Halts are driven under all four combinations of `idle_en` with `keep_sysclk` or with watchdog/detector state. These runs separate the SLEEP0, SLEEP1, IDLE0 and IDLE1 choices, and they are repeated from NORMAL, SLOW and SPINUP so that the saved return mode is tested too. Clock-select sweeps cover all eight divider codes with both `fast_sel` values, and `hosc_ready` arrives late, early or not at all. These sweeps separate the settle, abort and wait paths out of SPINUP. Coincident events probe the priority rules: halt with a select change, halt with `pd_clr`, halt with `wdt_expire`, and halt while already asleep. A long random phase then mixes all inputs, and a behavioural model is compared on every cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_NORMAL = 3'd0,
        PM_SLOW   = 3'd1,
        PM_SLEEP0 = 3'd2,
        PM_SLEEP1 = 3'd3,
        PM_IDLE0  = 3'd4,
        PM_IDLE1  = 3'd5,
        PM_SPINUP = 3'd6
    } pm_state_e;

    function automatic logic is_low_power(input pm_state_e s);
        return (s == PM_SLEEP0) || (s == PM_SLEEP1) ||
               (s == PM_IDLE0)  || (s == PM_IDLE1);
    endfunction
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int SLOW_CODES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div_sel,
    input  logic             fast_sel,
    input  logic             idle_en,
    input  logic             keep_sysclk,
    input  logic             wdt_on,
    input  logic             lvd_on,
    input  logic             halt_req,
    input  logic             wake_evt,
    input  logic             hosc_ready,
    output pm_state_e        state_q,
    output pm_state_e        ret_q,
    output logic             enter_lp,
    output logic             enter_deep
);
    localparam logic [DIV_W-1:0] SLOW_LIMIT = DIV_W'(SLOW_CODES);

    logic      want_slow;
    pm_state_e lp_target;
    pm_state_e state_d;
    pm_state_e ret_d;

    assign want_slow = !fast_sel && (clk_div_sel < SLOW_LIMIT);

    always_comb begin
        if (idle_en)
            lp_target = keep_sysclk ? PM_IDLE1 : PM_IDLE0;
        else
            lp_target = (wdt_on || lvd_on) ? PM_SLEEP1 : PM_SLEEP0;
    end

    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        enter_lp = 1'b0;
        unique case (state_q)
            PM_NORMAL: begin
                if (halt_req) begin
                    enter_lp = 1'b1;
                    state_d  = lp_target;
                    ret_d    = PM_NORMAL;
                end else if (want_slow) begin
                    state_d = PM_SLOW;
                end
            end
            PM_SLOW: begin
                if (halt_req) begin
                    enter_lp = 1'b1;
                    state_d  = lp_target;
                    ret_d    = PM_SLOW;
                end else if (!want_slow) begin
                    state_d = PM_SPINUP;
                end
            end
            PM_SPINUP: begin
                if (halt_req) begin
                    enter_lp = 1'b1;
                    state_d  = lp_target;
                    ret_d    = PM_SLOW;
                end else if (want_slow) begin
                    state_d = PM_SLOW;
                end else if (hosc_ready) begin
                    state_d = PM_NORMAL;
                end
            end
            PM_SLEEP0, PM_SLEEP1, PM_IDLE0, PM_IDLE1: begin
                if (wake_evt) state_d = ret_q;
            end
            default: state_d = PM_NORMAL;
        endcase
    end

    assign enter_deep = enter_lp && (lp_target == PM_SLEEP0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_NORMAL;
            ret_q   <= PM_NORMAL;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    assert_lp_halt_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_low_power(state_q) && !wake_evt) |=> $stable(state_q));

    assert_wake_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_low_power(state_q) && wake_evt) |=> (state_q == $past(ret_q)));

    assert_spinup_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SPINUP && !hosc_ready && !halt_req && !want_slow)
        |=> (state_q == PM_SPINUP));

    assert_halt_enters_lp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_low_power(state_q) && halt_req) |=> is_low_power(state_q));

    assert_return_is_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_q == PM_NORMAL) || (ret_q == PM_SLOW));
endmodule

// File: rtl/pwr_clk_gates.sv
module pwr_clk_gates
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_q,
    input  pm_state_e ret_q,
    output logic      cpu_clk_en,
    output logic      sys_clk_en,
    output logic      wdt_clk_en,
    output logic      tbase_clk_en,
    output logic      hs_clk_sel
);
    always_comb begin
        cpu_clk_en   = 1'b0;
        sys_clk_en   = 1'b0;
        wdt_clk_en   = 1'b1;
        tbase_clk_en = 1'b1;
        hs_clk_sel   = 1'b0;
        unique case (state_q)
            PM_NORMAL: begin
                cpu_clk_en = 1'b1;
                sys_clk_en = 1'b1;
                hs_clk_sel = 1'b1;
            end
            PM_SLOW, PM_SPINUP: begin
                cpu_clk_en = 1'b1;
                sys_clk_en = 1'b1;
            end
            PM_SLEEP0: begin
                wdt_clk_en   = 1'b0;
                tbase_clk_en = 1'b0;
                hs_clk_sel   = (ret_q == PM_NORMAL);
            end
            PM_SLEEP1: begin
                tbase_clk_en = 1'b0;
                hs_clk_sel   = (ret_q == PM_NORMAL);
            end
            PM_IDLE0: begin
                hs_clk_sel = (ret_q == PM_NORMAL);
            end
            PM_IDLE1: begin
                sys_clk_en = 1'b1;
                hs_clk_sel = (ret_q == PM_NORMAL);
            end
            default: begin
                cpu_clk_en = 1'b1;
                sys_clk_en = 1'b1;
            end
        endcase
    end

    assert_cpu_needs_sys_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> sys_clk_en);

    assert_tbase_needs_wdt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_clk_en |-> wdt_clk_en);
endmodule

// File: rtl/pwr_status_flags.sv
module pwr_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_lp,
    input  logic enter_deep,
    input  logic pd_clr,
    input  logic wdt_expire,
    output logic pd_flag,
    output logic to_flag,
    output logic wdt_clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_flag <= 1'b0;
            to_flag <= 1'b0;
            wdt_clr <= 1'b0;
        end else begin
            wdt_clr <= enter_deep;
            if (enter_lp)    pd_flag <= 1'b1;
            else if (pd_clr) pd_flag <= 1'b0;
            if (enter_lp)        to_flag <= 1'b0;
            else if (wdt_expire) to_flag <= 1'b1;
        end
    end

    assert_wdt_clr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    assert_pd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && !pd_clr) |=> pd_flag);

    assert_halt_clears_to_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enter_lp |=> (!to_flag && pd_flag));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int DIV_W      = 3,
    parameter int SLOW_CODES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div_sel,
    input  logic             fast_sel,
    input  logic             idle_en,
    input  logic             keep_sysclk,
    input  logic             wdt_on,
    input  logic             lvd_on,
    input  logic             halt_req,
    input  logic             wake_evt,
    input  logic             hosc_ready,
    input  logic             pd_clr,
    input  logic             wdt_expire,
    output logic [2:0]       mode,
    output logic             cpu_clk_en,
    output logic             sys_clk_en,
    output logic             wdt_clk_en,
    output logic             tbase_clk_en,
    output logic             hs_clk_sel,
    output logic             wdt_clr,
    output logic             pd_flag,
    output logic             to_flag
);
    pm_state_e state_q;
    pm_state_e ret_q;
    logic      enter_lp;
    logic      enter_deep;

    pwr_mode_fsm #(.DIV_W(DIV_W), .SLOW_CODES(SLOW_CODES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_div_sel (clk_div_sel),
        .fast_sel    (fast_sel),
        .idle_en     (idle_en),
        .keep_sysclk (keep_sysclk),
        .wdt_on      (wdt_on),
        .lvd_on      (lvd_on),
        .halt_req    (halt_req),
        .wake_evt    (wake_evt),
        .hosc_ready  (hosc_ready),
        .state_q     (state_q),
        .ret_q       (ret_q),
        .enter_lp    (enter_lp),
        .enter_deep  (enter_deep)
    );

    pwr_clk_gates u_gates (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .ret_q        (ret_q),
        .cpu_clk_en   (cpu_clk_en),
        .sys_clk_en   (sys_clk_en),
        .wdt_clk_en   (wdt_clk_en),
        .tbase_clk_en (tbase_clk_en),
        .hs_clk_sel   (hs_clk_sel)
    );

    pwr_status_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_lp   (enter_lp),
        .enter_deep (enter_deep),
        .pd_clr     (pd_clr),
        .wdt_expire (wdt_expire),
        .pd_flag    (pd_flag),
        .to_flag    (to_flag),
        .wdt_clr    (wdt_clr)
    );

    assign mode = state_q;

    assert_deep_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> (mode == 3'd2));

    assert_deep_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (!sys_clk_en && !wdt_clk_en && !tbase_clk_en));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_div_sel = 3'd2;
    logic       fast_sel = 1'b1, idle_en = 1'b0, keep_sysclk = 1'b0;
    logic       wdt_on = 1'b0, lvd_on = 1'b0, halt_req = 1'b0, wake_evt = 1'b0;
    logic       hosc_ready = 1'b0, pd_clr = 1'b0, wdt_expire = 1'b0;
    logic [2:0] mode;
    logic       cpu_clk_en, sys_clk_en, wdt_clk_en, tbase_clk_en, hs_clk_sel;
    logic       wdt_clr, pd_flag, to_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state (codes: 0 NORMAL,1 SLOW,2 SLEEP0,3 SLEEP1,4 IDLE0,5 IDLE1,6 SPINUP)
    int m_mode, m_ret;
    bit m_pd, m_to, m_wclr;

    always #5 clk = ~clk;

    pwr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel), .fast_sel(fast_sel),
        .idle_en(idle_en), .keep_sysclk(keep_sysclk), .wdt_on(wdt_on), .lvd_on(lvd_on),
        .halt_req(halt_req), .wake_evt(wake_evt), .hosc_ready(hosc_ready),
        .pd_clr(pd_clr), .wdt_expire(wdt_expire), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .wdt_clk_en(wdt_clk_en),
        .tbase_clk_en(tbase_clk_en), .hs_clk_sel(hs_clk_sel), .wdt_clr(wdt_clr),
        .pd_flag(pd_flag), .to_flag(to_flag)
    );

    function automatic bit in_lp(int m);
        return (m >= 2) && (m <= 5);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_ret = 0; m_pd = 0; m_to = 0; m_wclr = 0;
        end else begin
            bit slow_req, took;
            int tgt;
            slow_req = !fast_sel && (clk_div_sel <= 3'd1);
            if (idle_en) tgt = keep_sysclk ? 5 : 4;
            else         tgt = (wdt_on || lvd_on) ? 3 : 2;
            took = halt_req && !in_lp(m_mode);      // R8, R12
            m_wclr = took && (tgt == 2);             // R11
            if (took) begin m_pd = 1; m_to = 0; end  // R9, R10
            else begin
                if (pd_clr) m_pd = 0;
                if (wdt_expire) m_to = 1;
            end
            if (took) begin
                m_ret = (m_mode == 0) ? 0 : 1;       // R7
                m_mode = tgt;                         // R4, R5
            end else if (in_lp(m_mode)) begin
                if (wake_evt) m_mode = m_ret;
            end else if (m_mode == 0) begin
                if (slow_req) m_mode = 1;             // R2
            end else if (m_mode == 1) begin
                if (!slow_req) m_mode = 6;            // R3
            end else begin
                if (slow_req) m_mode = 1;
                else if (hosc_ready) m_mode = 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string rq;
            rq = (m_mode == 0 && !rst_n) ? "R1" : "R2/R3/R4/R5/R7";
            chk(rq, "mode", int'(mode), m_mode);
            chk("R6", "cpu_clk_en", int'(cpu_clk_en), (m_mode <= 1 || m_mode == 6) ? 1 : 0);
            chk("R6", "sys_clk_en", int'(sys_clk_en), (m_mode <= 1 || m_mode >= 5) ? 1 : 0);
            chk("R6", "wdt_clk_en", int'(wdt_clk_en), (m_mode == 2) ? 0 : 1);
            chk("R6", "tbase_clk_en", int'(tbase_clk_en), (m_mode == 2 || m_mode == 3) ? 0 : 1);
            chk("R6", "hs_clk_sel", int'(hs_clk_sel),
                (m_mode == 0 || (in_lp(m_mode) && m_ret == 0)) ? 1 : 0);
            chk("R11", "wdt_clr", int'(wdt_clr), int'(m_wclr));
            chk("R9", "pd_flag", int'(pd_flag), int'(m_pd));
            chk("R10", "to_flag", int'(to_flag), int'(m_to));
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_halt();
        halt_req = 1; step(); halt_req = 0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1; step(); wake_evt = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;                        // R1 reset state compared above
        step(2);
        // R2: both slow codes, then back via fast_sel with late oscillator (R3)
        for (int c = 0; c < 8; c++) begin
            fast_sel = 0; clk_div_sel = 3'(c); step(2);
            fast_sel = (c % 2 == 0); step(4);
            hosc_ready = 1; step(2); hosc_ready = 0;
        end
        // R3 abort: spin-up then return to slow selection
        fast_sel = 0; clk_div_sel = 0; step(2);
        clk_div_sel = 3'd5; step(3); clk_div_sel = 3'd1; step(2);
        clk_div_sel = 3'd3; hosc_ready = 1; step(3); hosc_ready = 0;
        // R4/R5 all halt targets, from NORMAL, SLOW and SPINUP; R8 halt while asleep
        for (int src = 0; src < 3; src++) begin
            for (int k = 0; k < 4; k++) begin
                fast_sel = 1; clk_div_sel = 3'd4; hosc_ready = 1; step(3); hosc_ready = 0;
                if (src >= 1) begin fast_sel = 0; clk_div_sel = 0; step(2); end
                if (src == 2) begin fast_sel = 1; step(2); end
                idle_en = k[1]; keep_sysclk = k[0]; wdt_on = k[0]; lvd_on = 0;
                wdt_expire = 1; step(); wdt_expire = 0;      // R10 set
                pulse_halt(); step(2);
                pulse_halt(); step(2);                        // R8
                pd_clr = 1; step(); pd_clr = 0;               // R9 clear
                pulse_wake(); step(2);                        // R7
            end
        end
        // R12 halt with clock change; R9/R10 coincident events; R4 via lvd
        fast_sel = 1; hosc_ready = 1; step(3);
        idle_en = 0; wdt_on = 0; lvd_on = 1;
        fast_sel = 0; clk_div_sel = 0; halt_req = 1; pd_clr = 1; wdt_expire = 1;
        step(); halt_req = 0; pd_clr = 0; wdt_expire = 0; step(2);
        pulse_wake(); step(3);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            halt_req    = ($urandom_range(0, 5) == 0);
            wake_evt    = ($urandom_range(0, 7) == 0);
            hosc_ready  = ($urandom_range(0, 2) == 0);
            pd_clr      = ($urandom_range(0, 9) == 0);
            wdt_expire  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 5) == 0) clk_div_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) fast_sel = $urandom_range(0, 1) != 0;
            idle_en     = $urandom_range(0, 1) != 0;
            keep_sysclk = $urandom_range(0, 1) != 0;
            wdt_on      = ($urandom_range(0, 2) == 0);
            lvd_on      = ($urandom_range(0, 2) == 0);
            step();
        end
        // mid-run reset back to R1 state
        rst_n = 0; step(2); rst_n = 1; step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule